// File: doc/BRIEF.md
# Tick-Snapshot Statistics Counter Bank

This block counts error events for a multi-lane receive path and shows software a frozen copy of those counts. Each lane has a one-bit event input, and a few extra one-bit inputs cover link-wide events. Each source feeds a hidden saturating accumulator. Software writes a single trigger word. That write copies every accumulator into its own holding register and restarts all accumulators on the same clock edge, so every count that software reads covers the same interval. A built-in source that is always active counts clock cycles in the same way, which gives the length of that interval.

The register port is a plain single-cycle read/write interface with no back-pressure. A read request is always accepted. Its data appears on `reg_rdata` after the next clock edge and stays there until the next read. Each counter takes an 8-byte slot. The low word of the counter is at the slot base and the high part is 4 bytes above it. The trigger word sits in slot 0, at byte 0x000.

Top module: `stat_snap_bank`

## Requirements
- R1: In every clock cycle where a lane or global event input is high, that source's accumulator grows by one. Software sees the result only through the holding register, after a trigger write.
- R2: A write to byte address 0x000 is a trigger. On that clock edge all holding registers take the accumulator values, and all accumulators restart. The value on `reg_wdata` plays no part.
- R3: An event that is high in the same cycle as a trigger write goes into the new interval. The accumulator for that source reads 1 after the edge, so no event is lost.
- R4: The cycle-count slot (slot 1, byte 0x008) holds the number of clock edges from one trigger edge to the next. For the first trigger after reset, it holds the number of edges since reset was released.
- R5: Every accumulator stops at 2^CNT_W-1 and never wraps.
- R6: A holding register does not change in any cycle without a trigger write.
- R7: Slot s starts at byte 8*s. addr[2]=0 returns counter bits LO_W-1:0 and addr[2]=1 returns bits CNT_W-1:LO_W, both zero-extended. addr[1:0] are ignored. Slot 1 is the cycle count, slots 2..1+NUM_GLOBAL are the global events in index order, and the lanes follow in index order.
- R8: A read of slot 0, or of any slot above the last counter, returns zero.
- R9: A write to any address other than word 0 changes nothing: no snapshot is taken and no accumulator restarts.
- R10: `reg_rdata` loads on the edge where `reg_rd` is high and holds its value on every other edge.
- R11: After reset, all accumulators, all holding registers and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_evt | input | NUM_LANES | One event pulse per lane per cycle |
| glob_evt | input | NUM_GLOBAL | Link-wide event pulses |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | DATA_W | Write data (ignored) |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
Two functions can fall on the same edge: an event arriving and a trigger restarting the accumulators. The bench provokes this by holding every event input high during a trigger write, then idling and triggering again. Every slot must then read exactly 1, and the cycle count must equal the number of idle edges plus one. Non-trigger writes are mixed between event bursts, and the counts that follow must show that nothing was cleared. A long burst on a single lane drives both that lane and the cycle count into saturation.

// File: rtl/stat_snap_pkg.sv
package stat_snap_pkg;
  localparam int SLOT_BYTES = 8;
  localparam int TRIG_SLOT  = 0;
  localparam int CYC_SLOT   = 1;
  typedef enum logic { WORD_LO = 1'b0, WORD_HI = 1'b1 } word_sel_e;
endpackage

// File: rtl/stat_snap_cell.sv
module stat_snap_cell #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             evt,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] acc_q, hold_q;
  logic [CNT_W-1:0] acc_nxt;

  always_comb begin
    if (tick)             acc_nxt = {{(CNT_W-1){1'b0}}, evt};
    else if (acc_q == TOP) acc_nxt = TOP;
    else                  acc_nxt = acc_q + {{(CNT_W-1){1'b0}}, evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= '0;
    end else begin
      acc_q <= acc_nxt;
      if (tick) hold_q <= acc_q;
    end
  end

  assign acc_o  = acc_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/stat_snap_decode.sv
module stat_snap_decode
  import stat_snap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NCNT   = 15,
  parameter int IDX_W  = 4
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              tick,
  output logic              hit,
  output word_sel_e         wsel,
  output logic [IDX_W-1:0]  idx
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  int unsigned       slot_i;

  assign slot   = addr[ADDR_W-1:3];
  assign slot_i = 32'(slot);
  assign tick   = wr && (addr[ADDR_W-1:2] == '0);
  assign hit    = (slot_i != TRIG_SLOT) && (slot_i <= NCNT);
  assign wsel   = addr[2] ? WORD_HI : WORD_LO;
  assign idx    = IDX_W'(slot_i - CYC_SLOT);
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
  import stat_snap_pkg::*;
#(
  parameter int NUM_LANES  = 12,
  parameter int NUM_GLOBAL = 2,
  parameter int CNT_W      = 48,
  parameter int LO_W       = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LANES-1:0]  lane_evt,
  input  logic [NUM_GLOBAL-1:0] glob_evt,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata
);
  localparam int NCNT  = 1 + NUM_GLOBAL + NUM_LANES;
  localparam int IDX_W = (NCNT > 1) ? $clog2(NCNT) : 1;

  logic [NCNT-1:0]             evt_vec;
  logic [NCNT-1:0][CNT_W-1:0]  acc_q;
  logic [NCNT-1:0][CNT_W-1:0]  hold_q;
  logic                        tick_w, hit_w;
  word_sel_e                   wsel_w;
  logic [IDX_W-1:0]            idx_w;
  logic [CNT_W-1:0]            sel_cnt;
  logic [DATA_W-1:0]           rd_word;
  logic                        unused_wdata;

  assign unused_wdata = ^reg_wdata;
  // slot order: cycle count, globals, lanes
  assign evt_vec = {lane_evt, glob_evt, 1'b1};

  stat_snap_decode #(.ADDR_W(ADDR_W), .NCNT(NCNT), .IDX_W(IDX_W)) u_dec (
    .wr   (reg_wr),
    .addr (reg_addr),
    .tick (tick_w),
    .hit  (hit_w),
    .wsel (wsel_w),
    .idx  (idx_w)
  );

  for (genvar c = 0; c < NCNT; c++) begin : g_cell
    stat_snap_cell #(.CNT_W(CNT_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_w),
      .evt    (evt_vec[c]),
      .acc_o  (acc_q[c]),
      .hold_o (hold_q[c])
    );
  end

  always_comb begin
    sel_cnt = hit_w ? hold_q[idx_w] : '0;
    if (!hit_w)                rd_word = '0;
    else if (wsel_w == WORD_HI) rd_word = DATA_W'(sel_cnt[CNT_W-1:LO_W]);
    else                       rd_word = DATA_W'(sel_cnt[LO_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_word;
  end
endmodule

// File: rtl/stat_snap_bank_chk.sv
module stat_snap_bank_chk #(
  parameter int NCNT   = 15,
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic [CNT_W-1:0]        cyc_acc,
  input logic [CNT_W-1:0]        cyc_hold,
  input logic [NCNT*CNT_W-1:0]   hold_all
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic trig, reserved;
  assign trig     = reg_wr && (reg_addr[ADDR_W-1:2] == '0);
  assign reserved = (reg_addr[ADDR_W-1:3] == '0) || (32'(reg_addr[ADDR_W-1:3]) > NCNT);

  a_r2_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cyc_hold == $past(cyc_acc));
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cyc_acc == CNT_W'(1));
  a_r4_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && cyc_acc != TOP) |=> cyc_acc == $past(cyc_acc) + CNT_W'(1));
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && cyc_acc == TOP) |=> cyc_acc == TOP);
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(hold_all));
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reserved) |=> reg_rdata == '0);
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind stat_snap_bank stat_snap_bank_chk #(
  .NCNT(NCNT), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .cyc_acc   (acc_q[0]),
  .cyc_hold  (hold_q[0]),
  .hold_all  (hold_q)
);

// File: tb/stat_snap_bank_bench.sv
module stat_snap_bank_bench;
  localparam int NL = 3, NG = 2, CW = 10, LO = 6, DW = 32, AW = 8;
  localparam int NC = 1 + NG + NL;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] lane_evt = '0;
  logic [NG-1:0] glob_evt = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, trig_int = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  int errors = 0, checks = 0;
  logic [CW-1:0] m_acc [NC];
  logic [CW-1:0] m_hold[NC];

  always #4 clk = ~clk;

  stat_snap_bank #(.NUM_LANES(NL), .NUM_GLOBAL(NG), .CNT_W(CW), .LO_W(LO),
                   .DATA_W(DW), .ADDR_W(AW)) u_stat_snap_bank (
    .clk(clk), .rst_n(rst_n), .lane_evt(lane_evt), .glob_evt(glob_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // reference counts built from the requirements
  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      logic e;
      e = (c == 0) ? 1'b1 : (c <= NG) ? glob_evt[c-1] : lane_evt[c-1-NG];
      if (!rst_n) begin
        m_acc[c] <= '0; m_hold[c] <= '0;
      end else if (trig_int) begin
        m_hold[c] <= m_acc[c]; m_acc[c] <= CW'(e);
      end else if (m_acc[c] != MAXV) begin
        m_acc[c] <= m_acc[c] + CW'(e);
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd_word(logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_cnt(int s, output logic [63:0] v);
    logic [DW-1:0] lo, hi;
    rd_word(AW'(8*s), lo);
    rd_word(AW'(8*s+4), hi);
    v = (64'(hi) << LO) | 64'(lo);
  endtask

  task automatic check_all(string req);
    for (int s = 1; s <= NC; s++) begin
      logic [63:0] v;
      rd_cnt(s, v);
      chk(req, v, 64'(m_hold[s-1]));
    end
  endtask

  task automatic tick(logic [NL-1:0] le, logic [NG-1:0] ge);
    reg_wr = 1'b1; reg_addr = '0; reg_wdata = 32'hA5A5_1234; trig_int = 1'b1;
    lane_evt = le; glob_evt = ge;
    @(negedge clk);
    reg_wr = 1'b0; trig_int = 1'b0; lane_evt = '0; glob_evt = '0;
  endtask

  task automatic wr_other(logic [AW-1:0] a);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = '1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pat(int n, int kind);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < NL; i++) lane_evt[i] = ((k + kind) % (i + 2)) == 0;
      for (int g = 0; g < NG; g++) glob_evt[g] = ((k * (g + 1) + kind) % 3) == 1;
      @(negedge clk);
    end
    lane_evt = '0; glob_evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, d2;
    logic [63:0] v, keep;
    repeat (3) @(negedge clk);
    chk("R11 rdata after reset", 64'(reg_rdata), 0);
    rst_n = 1'b1;
    check_all("R11 counters after reset");

    pat(40, 0);
    tick('0, '0);
    check_all("R1 R2 R4 R7 pattern A snapshot");
    rd_cnt(1, v);
    chk("R4 cycle count first interval", v, 64'(m_hold[0]));

    pat(25, 1);
    check_all("R6 holding unchanged without trigger");

    rd_cnt(NC, keep);
    rd_word(AW'(8*NC + 1), d);
    rd_word(AW'(8*NC), d2);
    chk("R7 addr[1:0] ignored", 64'(d), 64'(d2));
    repeat (4) @(negedge clk);
    chk("R10 rdata held without read", 64'(reg_rdata), 64'(d2));

    rd_word(AW'(8*NC), d);
    rd_word(8'h00, d);  chk("R8 trigger slot low reads zero", 64'(d), 0);
    rd_word(AW'(8*NC), d);
    rd_word(8'h04, d);  chk("R8 trigger slot high reads zero", 64'(d), 0);
    rd_word(AW'(8*NC), d);
    rd_word(AW'(8*(NC+1)), d); chk("R8 slot past last reads zero", 64'(d), 0);
    rd_word(8'hFC, d);  chk("R8 top address reads zero", 64'(d), 0);

    pat(10, 2);
    wr_other(8'h04); wr_other(8'h08); wr_other(8'h0C); wr_other(8'h20);
    check_all("R9 stray writes take no snapshot");
    tick('0, '0);
    check_all("R9 accumulators not cleared by stray writes");

    tick('1, '1);
    repeat (5) @(negedge clk);
    tick('0, '0);
    for (int s = 2; s <= NC; s++) begin
      rd_cnt(s, v);
      chk("R3 event on trigger edge counted once", v, 1);
    end
    rd_cnt(1, v);
    chk("R3 R4 cycle count after coincident trigger", v, 6);

    pat(17, 3);
    tick(3'b010, 2'b01);
    check_all("R2 second pattern snapshot");

    lane_evt = 3'b001;
    repeat (1100) @(negedge clk);
    lane_evt = '0;
    tick('0, '0);
    rd_cnt(1 + NG + 1, v);
    chk("R5 lane0 saturates", v, 64'(MAXV));
    rd_cnt(1, v);
    chk("R5 cycle count saturates", v, 64'(MAXV));
    rd_word(AW'(8*(NG+2) + 4), d);
    chk("R7 high word of saturated lane", 64'(d), 64'(MAXV >> LO));
    check_all("R5 full bank after saturation run");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule